// File: doc/BRIEF.md
# Phase Lock Detector with Hysteresis

This block watches the output of a QPSK carrier phase recovery loop and decides whether that loop is in lock. On every cycle where a symbol is flagged valid, it reads one derotated complex soft symbol and the expected reference amplitude A. It then forms a per-symbol lock statistic that depends only on the residual phase error. The statistic is the real part of the soft symbol multiplied by the conjugate of its own hard decision, which is |I| + |Q|. It does not depend on which of the four QPSK points was sent. It repeats every quarter turn of phase, and it peaks at 2A when the phase error is a multiple of π/2.

The statistic feeds a first-order recursive average. The forgetting factor is a power of two, 2^-n, so the update uses only a shift and no multiplier. After reset the average is preset to 1.75A, which lies below the out-of-lock level. A two-threshold comparator drives a registered lock flag. The flag sets only above 1.815A and clears only below 1.8A, so noise around a single level cannot cause repeated false lock or unlock events. The filtered metric and the flag are the block's outputs. All thresholds scale with the reference amplitude input.

Top module: `phase_lock_monitor`

## Requirements
- R1: The statistic for a valid symbol is z = |I| + |Q|. Sign changes of I or Q (the four QPSK quadrants) give the same z, and a symbol with I = Q = A gives the peak value z = 2A.
- R2: After reset, and until the first valid symbol, the metric output equals floor(A·1792/1024), which is 1.75A in ten-bit fixed point.
- R3: On each valid symbol the metric becomes l + floor((z − l) / 2^n), where l is the previous metric (the preset value for the first symbol) and n is shift_sel.
- R4: With shift_sel = 0, the metric after a valid symbol equals that symbol's z.
- R5: While sym_valid is low, neither the metric (once a valid symbol has been taken) nor the lock flag changes, whatever the symbol inputs carry.
- R6: When out of lock, the flag sets only if the updated metric is strictly greater than floor(A·1859/1024) (1.815A). A metric equal to that level does not set it.
- R7: When in lock, the flag clears only if the updated metric is strictly less than floor(A·1843/1024) (1.8A). A metric equal to that level does not clear it.
- R8: A metric between the two levels leaves the flag in its current state, whether that state is locked or unlocked.
- R9: Reset drives the lock flag low (out of lock).
- R10: The metric and the flag both take their new values at the clock edge that samples the valid symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Soft symbol on sym_i/sym_q is valid this cycle |
| sym_i | input | W | Derotated soft symbol, in-phase part (signed) |
| sym_q | input | W | Derotated soft symbol, quadrature part (signed) |
| ref_amp | input | W | Reference amplitude A (unsigned) |
| shift_sel | input | SW | Forgetting factor exponent n, γ = 2^-n |
| metric | output | W+1 | Filtered lock metric |
| locked | output | 1 | Lock flag, 1 = in lock |

## Verification
The hardest situation to reach from the ports is a metric that sits exactly on a threshold, or inside the narrow band between the two thresholds, while the flag is in a known state. With a long average, the metric only drifts toward such values, and it seldom lands on them exactly. The stimulus therefore sets shift_sel to zero, so that each symbol places the metric exactly at its |I| + |Q|. This walks the flag through both equality points and the hold band in either state. A separate sequence with a long average then checks the recursive update step by step against an independent model.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Fractional bits of the amplitude-relative level coefficients
  localparam int PLM_COEF_FB = 10;
  localparam int PLM_COEF_W  = 11;

  // Level coefficients relative to A, scaled by 2^PLM_COEF_FB
  localparam logic [PLM_COEF_W-1:0] PLM_K_PRESET = 11'd1792; // 1.75
  localparam logic [PLM_COEF_W-1:0] PLM_K_DROP   = 11'd1843; // 1.8
  localparam logic [PLM_COEF_W-1:0] PLM_K_GAIN   = 11'd1859; // 1.815

  localparam int PLM_NUM_LEVELS = 3;

  typedef enum logic {
    PLM_SEARCH = 1'b0,
    PLM_LOCKED = 1'b1
  } plm_state_e;

  function automatic logic [PLM_COEF_W-1:0] plm_level_coef(input int idx);
    case (idx)
      0:       return PLM_K_PRESET;
      1:       return PLM_K_DROP;
      default: return PLM_K_GAIN;
    endcase
  endfunction

endpackage

// File: rtl/plm_stat.sv
module plm_stat #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] s_i,
  input  logic signed [W-1:0] s_q,
  output logic        [W:0]   z
);

  // Magnitude widened by one bit so that the most negative input is exact
  function automatic logic [W:0] mag(input logic signed [W-1:0] v);
    logic [W:0] e;
    e = {v[W-1], v};
    return v[W-1] ? (~e + 1'b1) : e;
  endfunction

  // Re(y * conj(sgn(I) + j sgn(Q))) = |I| + |Q|
  function automatic logic [W:0] quad_stat(input logic signed [W-1:0] a,
                                           input logic signed [W-1:0] b);
    return mag(a) + mag(b);
  endfunction

  assign z = quad_stat(s_i, s_q);

endmodule

// File: rtl/plm_scale.sv
module plm_scale #(
  parameter int                             W    = 12,
  parameter logic [plm_pkg::PLM_COEF_W-1:0] COEF = 11'd1024
) (
  input  logic [W-1:0] amp,
  output logic [W:0]   level
);
  import plm_pkg::*;

  localparam int PW = W + PLM_COEF_W;

  function automatic logic [W:0] scale_amp(input logic [W-1:0] a);
    logic [PW-1:0] p;
    p = {{PLM_COEF_W{1'b0}}, a} * {{W{1'b0}}, COEF};
    return p[W+PLM_COEF_FB:PLM_COEF_FB];
  endfunction

  assign level = scale_amp(amp);

endmodule

// File: rtl/plm_filter.sv
module plm_filter #(
  parameter int W  = 12,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [W:0]    z,
  input  logic [W:0]    preset,
  input  logic [SW-1:0] sh,
  output logic [W:0]    metric,
  output logic [W:0]    l_next
);

  localparam int MW = W + 1;

  logic [MW-1:0] l_q;
  logic          primed_q;
  logic [MW-1:0] l_cur;

  // One recursion step: cur + floor((zin - cur) / 2^n), clamped to range
  function automatic logic [MW-1:0] smooth(input logic [MW-1:0] cur,
                                           input logic [MW-1:0] zin,
                                           input logic [SW-1:0] n);
    logic signed [MW+1:0] d;
    logic signed [MW+1:0] st;
    logic signed [MW+1:0] nx;
    d  = $signed({2'b00, zin}) - $signed({2'b00, cur});
    st = d >>> n;
    nx = $signed({2'b00, cur}) + st;
    if (nx[MW+1])    return '0;
    else if (nx[MW]) return '1;
    else             return nx[MW-1:0];
  endfunction

  assign l_cur  = primed_q ? l_q : preset;
  assign l_next = smooth(l_cur, z, sh);
  assign metric = l_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q      <= '0;
      primed_q <= 1'b0;
    end else if (valid) begin
      l_q      <= l_next;
      primed_q <= 1'b1;
    end
  end

  // R3
  metric_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> ((metric >= (($past(z) < $past(l_cur)) ? $past(z) : $past(l_cur))) &&
               (metric <= (($past(z) < $past(l_cur)) ? $past(l_cur) : $past(z)))));

  // R5
  metric_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !valid) |=> $stable(metric));

endmodule

// File: rtl/plm_hyst.sv
module plm_hyst #(
  parameter int W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [W:0] cand,
  input  logic [W:0] lo_thr,
  input  logic [W:0] hi_thr,
  output logic       locked
);
  import plm_pkg::*;

  plm_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (valid) begin
      case (st_q)
        PLM_SEARCH: if (cand > hi_thr) st_n = PLM_LOCKED;
        PLM_LOCKED: if (cand < lo_thr) st_n = PLM_SEARCH;
        default:    st_n = PLM_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PLM_SEARCH;
    else        st_q <= st_n;
  end

  assign locked = (st_q == PLM_LOCKED);

  // R6
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(valid) && ($past(cand) > $past(hi_thr))));

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(valid) && ($past(cand) < $past(lo_thr))));

  // R5
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(locked));

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int W  = 12,
  parameter int SW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_valid,
  input  logic signed [W-1:0] sym_i,
  input  logic signed [W-1:0] sym_q,
  input  logic        [W-1:0] ref_amp,
  input  logic       [SW-1:0] shift_sel,
  output logic          [W:0] metric,
  output logic                locked
);
  import plm_pkg::*;

  // Amplitude-scaled levels: 0 preset, 1 drop threshold, 2 gain threshold
  logic [W:0] level [PLM_NUM_LEVELS];
  logic [W:0] z;
  logic [W:0] l_next;

  for (genvar g = 0; g < PLM_NUM_LEVELS; g++) begin : g_level
    plm_scale #(.W(W), .COEF(plm_level_coef(g))) u_scale (
      .amp   (ref_amp),
      .level (level[g])
    );
  end

  plm_stat #(.W(W)) u_stat (
    .s_i (sym_i),
    .s_q (sym_q),
    .z   (z)
  );

  plm_filter #(.W(W), .SW(SW)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (sym_valid),
    .z      (z),
    .preset (level[0]),
    .sh     (shift_sel),
    .metric (metric),
    .l_next (l_next)
  );

  plm_hyst #(.W(W)) u_hyst (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (sym_valid),
    .cand   (l_next),
    .lo_thr (level[1]),
    .hi_thr (level[2]),
    .locked (locked)
  );

  // R9
  reset_flag_chk: assert property (@(posedge clk)
    !rst_n |-> !locked);

endmodule

// File: tb/phase_lock_monitor_tb.sv
`timescale 1ns/1ps
module phase_lock_monitor_tb;

  localparam int W  = 12;
  localparam int SW = 3;
  localparam int AMP = 1000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                sym_valid = 1'b0;
  logic signed [W-1:0] sym_i = '0;
  logic signed [W-1:0] sym_q = '0;
  logic        [W-1:0] ref_amp = AMP;
  logic       [SW-1:0] shift_sel = '0;
  logic          [W:0] metric;
  logic                locked;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Reference model state, derived from the requirements
  int mdl_l;
  int mdl_lock;
  int lvl_pre, lvl_lo, lvl_hi;

  always #2.5 clk = ~clk;

  phase_lock_monitor #(.W(W), .SW(SW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_i     (sym_i),
    .sym_q     (sym_q),
    .ref_amp   (ref_amp),
    .shift_sel (shift_sel),
    .metric    (metric),
    .locked    (locked)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int floor_div(input int num, input int n);
    int den;
    den = 1 << n;
    if (num >= 0) return num / den;
    return -((-num + den - 1) / den);
  endfunction

  task automatic model_step(input int i, input int q, input int n);
    int z;
    z = absv(i) + absv(q);
    mdl_l = mdl_l + floor_div(z - mdl_l, n);
    if (mdl_lock == 1 && mdl_l < lvl_lo) mdl_lock = 0;
    else if (mdl_lock == 0 && mdl_l > lvl_hi) mdl_lock = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mdl_l = lvl_pre;
    mdl_lock = 0;
    @(negedge clk);
  endtask

  // Present one valid symbol for one edge; outputs are read at the next negedge
  task automatic send(input int i, input int q);
    sym_i = i[W-1:0];
    sym_q = q[W-1:0];
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    model_step(i, q, int'(shift_sel));
  endtask

  task automatic t_reset();
    do_reset();
    check_val("R2 preset metric", int'(metric), lvl_pre);
    check_val("R9 reset flag", int'(locked), 0);
  endtask

  task automatic t_direct();
    do_reset();
    shift_sel = '0;
    send(950, 950);
    check_val("R4 metric equals z", int'(metric), 1900);
    check_val("R10 R6 flag after first edge", int'(locked), 1);
    send(-950, 950);
    check_val("R1 quadrant II", int'(metric), 1900);
    send(950, -950);
    check_val("R1 quadrant IV", int'(metric), 1900);
    send(-950, -950);
    check_val("R1 quadrant III", int'(metric), 1900);
    send(-AMP, AMP);
    check_val("R1 peak 2A", int'(metric), 2 * AMP);
  endtask

  task automatic t_hyst();
    do_reset();
    shift_sel = '0;
    send(950, 950);
    check_val("R6 locked start", int'(locked), 1);
    send(900, 900);
    check_val("R8 hold locked in band", int'(locked), 1);
    send(lvl_lo - 900, 900);
    check_val("R7 equal drop level keeps lock", int'(locked), 1);
    send(lvl_lo - 901, 900);
    check_val("R7 below drop level unlocks", int'(locked), 0);
    send(905, 905);
    check_val("R8 hold unlocked in band", int'(locked), 0);
    send(lvl_hi - 908, 908);
    check_val("R6 equal gain level stays unlocked", int'(locked), 0);
    send(lvl_hi - 907, 908);
    check_val("R6 above gain level locks", int'(locked), 1);
    check_val("R4 metric tracks z", int'(metric), lvl_hi + 1);
  endtask

  task automatic t_idle();
    int m0, f0;
    do_reset();
    shift_sel = '0;
    send(990, 990);
    m0 = int'(metric);
    f0 = int'(locked);
    sym_i = -12'sd2048;
    sym_q = 12'sd10;
    sym_valid = 1'b0;
    repeat (5) @(negedge clk);
    check_val("R5 metric held while idle", int'(metric), m0);
    check_val("R5 flag held while idle", int'(locked), f0);
  endtask

  task automatic t_filter();
    do_reset();
    shift_sel = 3'd3;
    for (int k = 0; k < 24; k++) begin
      send(1000, -1000);
      check_val("R3 rising metric", int'(metric), mdl_l);
      check_val("R6 flag rising", int'(locked), mdl_lock);
    end
    shift_sel = 3'd2;
    for (int k = 0; k < 16; k++) begin
      send(-700, 700);
      check_val("R3 falling metric", int'(metric), mdl_l);
      check_val("R7 flag falling", int'(locked), mdl_lock);
    end
    check_val("R7 ends unlocked", int'(locked), 0);
  endtask

  initial begin
    lvl_pre = (AMP * 1792) >> 10;
    lvl_lo  = (AMP * 1843) >> 10;
    lvl_hi  = (AMP * 1859) >> 10;
    t_reset();
    t_direct();
    t_hyst();
    t_idle();
    t_filter();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule